// File: doc/BRIEF.md
# Host Packet FIFO Interface

This block gives a packet router port the two buffers that face the host processor. The host writes outgoing words into a transmit buffer, and the link side drains that buffer. The link side fills a receive buffer that the host then reads. Each buffer stores 9-bit words. The low byte carries packet data. The top bit marks a packet terminator, and for a terminator the lowest bit tells a clean end from an error end.

On the host side the strobes are active low and are sampled on the rising clock edge. The read side is first-word-fall-through: the oldest stored word is already on the output before any pop. Each buffer has two status flags at fixed levels. The transmit buffer reports full and almost full. The receive buffer reports empty and almost empty. On the link side, outgoing words are decoded into a byte plus clean-end and error-end strobes. Incoming bytes and terminator kinds are encoded into the 9-bit word format. Both sides run on one clock, and any clock-domain crossing sits outside this block.

Top module: `host_pkt_fifo`

## Requirements
- R1: While rst_ni is low, and on the first cycle after it rises, both buffers are empty. tx_full_o, tx_afull_o, tx_link_valid_o, tx_link_eop_o, tx_link_eep_o and rx_link_full_o are 0, rx_empty_o and rx_aempty_o are 1, and rx_word_o and tx_link_data_o read 0.
- R2: A word on tx_word_i is stored on a rising edge where tx_push_ni is 0 and the buffer is not full. Stored words leave on the link side in write order, and tx_link_pop_i=1 removes the head while tx_link_valid_o is 1.
- R3: While rx_empty_o is 0, rx_word_o shows the oldest stored receive word, with no pop needed. It stays stable until a rising edge where rx_pop_ni is 0, which moves it to the next word.
- R4: A full flag (tx_full_o for transmit, rx_link_full_o for receive) is 1 exactly when DEPTH=128 words are stored. A push while full is ignored: the stored words and the flags stay as they were.
- R5: A pop while a buffer is empty (rx_pop_ni=0 with rx_empty_o=1, or tx_link_pop_i=1 with tx_link_valid_o=0) is ignored, and the buffer stays empty.
- R6: tx_afull_o is 1 exactly when ALMOST_GAP=8 or fewer free entries remain, that is when 120 or more words are stored.
- R7: rx_aempty_o is 1 exactly when 8 or fewer words are stored.
- R8: A push and a pop in the same cycle, on a buffer that is neither empty nor full, leave the stored count unchanged.
- R9: Receive link words are encoded by rx_link_kind_i. 2'b00 stores {1'b0, rx_link_data_i}, 2'b01 stores 9'h100 (clean end), and 2'b10 or 2'b11 stores 9'h101 (error end).
- R10: tx_link_data_o carries bits 7:0 of the head word. tx_link_eop_o is 1 when the head word has bit 8 set and bit 0 clear. tx_link_eep_o is 1 when the head word has bits 8 and 0 both set. All three read 0 while the transmit buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_word_i | input | 9 | Host word to transmit |
| tx_push_ni | input | 1 | Transmit push strobe, active low |
| tx_full_o | output | 1 | Transmit buffer full |
| tx_afull_o | output | 1 | Transmit buffer almost full |
| tx_link_pop_i | input | 1 | Link side takes the transmit head |
| tx_link_valid_o | output | 1 | Transmit head present |
| tx_link_data_o | output | 8 | Transmit head byte |
| tx_link_eop_o | output | 1 | Transmit head is a clean end |
| tx_link_eep_o | output | 1 | Transmit head is an error end |
| rx_link_push_i | input | 1 | Link side stores a receive word |
| rx_link_kind_i | input | 2 | 00 data, 01 clean end, 1x error end |
| rx_link_data_i | input | 8 | Receive data byte |
| rx_link_full_o | output | 1 | Receive buffer full |
| rx_word_o | output | 9 | Receive head word, falls through |
| rx_pop_ni | input | 1 | Receive pop strobe, active low |
| rx_empty_o | output | 1 | Receive buffer empty |
| rx_aempty_o | output | 1 | Receive buffer almost empty |

## Verification
The bench builds the block with its default DEPTH=128 and ALMOST_GAP=8. At these values it fills each buffer to capacity in a few hundred cycles. That puts the full boundary, the 120-word almost-full edge, the 8-word almost-empty edge and pointer wrap-around all within a short run. The bench also holds the transmit buffer at 119 and at 120 words while pushing and popping in the same cycle, which checks that the count holds steady on both sides of the almost-full edge.

// File: rtl/host_fifo_pkg.sv
package host_fifo_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] fifo_word_t;
  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_EOP  = 2'b01,
    KIND_EEP  = 2'b10,
    KIND_EEPX = 2'b11
  } term_kind_e;
  localparam fifo_word_t WORD_EOP = 9'h100;
  localparam fifo_word_t WORD_EEP = 9'h101;
endpackage

// File: rtl/fifo_store.sv
module fifo_store #(
  parameter int unsigned DEPTH = 128,
  parameter int unsigned W     = 9,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  output logic [CW-1:0] count_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic [CW-1:0] cnt_q;
  logic          wr_en, rd_en;

  // full blocks a push even when a pop happens in the same cycle
  assign wr_en = push_i && (cnt_q != FULL);
  assign rd_en = pop_i && (cnt_q != '0);

  always_ff @(posedge clk_i) begin
    if (wr_en) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (wr_en) wr_ptr_q <= (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
      if (rd_en) rd_ptr_q <= (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // head word falls through; masked when empty
  assign rdata_o = (cnt_q == '0) ? '0 : mem_q[rd_ptr_q];
  assign count_o = cnt_q;
endmodule

// File: rtl/term_encode.sv
module term_encode
  import host_fifo_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic [7:0] data_i,
  output fifo_word_t word_o
);
  always_comb begin
    unique case (term_kind_e'(kind_i))
      KIND_DATA: word_o = {1'b0, data_i};
      KIND_EOP:  word_o = WORD_EOP;
      default:   word_o = WORD_EEP;
    endcase
  end
endmodule

// File: rtl/term_decode.sv
module term_decode
  import host_fifo_pkg::*;
(
  input  fifo_word_t word_i,
  input  logic       valid_i,
  output logic [7:0] data_o,
  output logic       eop_o,
  output logic       eep_o
);
  assign data_o = word_i[7:0];
  assign eop_o  = valid_i && word_i[8] && !word_i[0];
  assign eep_o  = valid_i && word_i[8] && word_i[0];
endmodule

// File: rtl/host_pkt_fifo.sv
module host_pkt_fifo
  import host_fifo_pkg::*;
#(
  parameter int unsigned DEPTH      = 128,
  parameter int unsigned ALMOST_GAP = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [8:0] tx_word_i,
  input  logic       tx_push_ni,
  output logic       tx_full_o,
  output logic       tx_afull_o,
  input  logic       tx_link_pop_i,
  output logic       tx_link_valid_o,
  output logic [7:0] tx_link_data_o,
  output logic       tx_link_eop_o,
  output logic       tx_link_eep_o,
  input  logic       rx_link_push_i,
  input  logic [1:0] rx_link_kind_i,
  input  logic [7:0] rx_link_data_i,
  output logic       rx_link_full_o,
  output logic [8:0] rx_word_o,
  input  logic       rx_pop_ni,
  output logic       rx_empty_o,
  output logic       rx_aempty_o
);
  localparam int unsigned   CW     = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL   = CW'(DEPTH);
  localparam logic [CW-1:0] AF_LVL = CW'(DEPTH - ALMOST_GAP);
  localparam logic [CW-1:0] AE_LVL = CW'(ALMOST_GAP);

  logic [CW-1:0] tx_cnt, rx_cnt;
  fifo_word_t    tx_head, rx_in;

  fifo_store #(.DEPTH(DEPTH), .W(WORD_W)) i_tx_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (!tx_push_ni),
    .pop_i   (tx_link_pop_i),
    .wdata_i (tx_word_i),
    .rdata_o (tx_head),
    .count_o (tx_cnt)
  );

  assign tx_full_o       = (tx_cnt == FULL);
  assign tx_afull_o      = (tx_cnt >= AF_LVL);
  assign tx_link_valid_o = (tx_cnt != '0);

  term_decode i_tx_decode (
    .word_i  (tx_head),
    .valid_i (tx_link_valid_o),
    .data_o  (tx_link_data_o),
    .eop_o   (tx_link_eop_o),
    .eep_o   (tx_link_eep_o)
  );

  term_encode i_rx_encode (
    .kind_i (rx_link_kind_i),
    .data_i (rx_link_data_i),
    .word_o (rx_in)
  );

  fifo_store #(.DEPTH(DEPTH), .W(WORD_W)) i_rx_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (rx_link_push_i),
    .pop_i   (!rx_pop_ni),
    .wdata_i (rx_in),
    .rdata_o (rx_word_o),
    .count_o (rx_cnt)
  );

  assign rx_link_full_o = (rx_cnt == FULL);
  assign rx_empty_o     = (rx_cnt == '0);
  assign rx_aempty_o    = (rx_cnt <= AE_LVL);
endmodule

// File: rtl/host_pkt_fifo_chk.sv
module host_pkt_fifo_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [8:0] tx_word_i,
  input logic       tx_push_ni,
  input logic       tx_full_o,
  input logic       tx_afull_o,
  input logic       tx_link_pop_i,
  input logic       tx_link_valid_o,
  input logic [7:0] tx_link_data_o,
  input logic       tx_link_eop_o,
  input logic       tx_link_eep_o,
  input logic       rx_link_push_i,
  input logic [1:0] rx_link_kind_i,
  input logic [7:0] rx_link_data_i,
  input logic       rx_link_full_o,
  input logic [8:0] rx_word_o,
  input logic       rx_pop_ni,
  input logic       rx_empty_o,
  input logic       rx_aempty_o
);
  // R4
  full_push_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o && !tx_push_ni && !tx_link_pop_i |=> tx_full_o && $stable(tx_link_data_o));

  // R5
  empty_pop_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o && !rx_pop_ni && !rx_link_push_i |=> rx_empty_o);

  // R3
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_empty_o && rx_pop_ni |=> !rx_empty_o && $stable(rx_word_o));

  // R6
  afull_covers_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> tx_afull_o);

  // R7
  aempty_covers_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o |-> rx_aempty_o);

  // R10
  idle_no_term_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_link_valid_o |-> !tx_link_eop_o && !tx_link_eep_o && tx_link_data_o == 8'h00);

  // R9
  eop_encode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_empty_o && rx_link_push_i && rx_link_kind_i == 2'b01 |=> rx_word_o == 9'h100);
endmodule

bind host_pkt_fifo host_pkt_fifo_chk i_chk (.*);

// File: tb/test_host_pkt_fifo.sv
module test_host_pkt_fifo;
  localparam int DEPTH = 128;
  localparam int GAP   = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic [8:0] tx_word_i;
  logic       tx_push_ni;
  logic       tx_full_o, tx_afull_o;
  logic       tx_link_pop_i;
  logic       tx_link_valid_o;
  logic [7:0] tx_link_data_o;
  logic       tx_link_eop_o, tx_link_eep_o;
  logic       rx_link_push_i;
  logic [1:0] rx_link_kind_i;
  logic [7:0] rx_link_data_i;
  logic       rx_link_full_o;
  logic [8:0] rx_word_o;
  logic       rx_pop_ni;
  logic       rx_empty_o, rx_aempty_o;

  int checks = 0;
  int errors = 0;
  logic [8:0] tx_q[$];
  logic [8:0] rx_q[$];

  always #2.5 clk_i = ~clk_i;

  host_pkt_fifo i_host_pkt_fifo (.*);

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    logic [8:0] th, rh;
    th = (tx_q.size() > 0) ? tx_q[0] : 9'h000;
    rh = (rx_q.size() > 0) ? rx_q[0] : 9'h000;
    chk(tx_full_o == (tx_q.size() == DEPTH), "R4", "tx_full", tx_full_o, tx_q.size() == DEPTH);
    chk(tx_afull_o == (tx_q.size() >= DEPTH - GAP), "R6", "tx_afull", tx_afull_o, tx_q.size() >= DEPTH - GAP);
    chk(tx_link_valid_o == (tx_q.size() > 0), "R2", "tx_valid", tx_link_valid_o, tx_q.size() > 0);
    chk(tx_link_data_o == th[7:0], "R2", "tx_data", tx_link_data_o, th[7:0]);
    chk(tx_link_eop_o == (th[8] && !th[0]), "R10", "tx_eop", tx_link_eop_o, th[8] && !th[0]);
    chk(tx_link_eep_o == (th[8] && th[0]), "R10", "tx_eep", tx_link_eep_o, th[8] && th[0]);
    chk(rx_link_full_o == (rx_q.size() == DEPTH), "R4", "rx_full", rx_link_full_o, rx_q.size() == DEPTH);
    chk(rx_empty_o == (rx_q.size() == 0), "R5", "rx_empty", rx_empty_o, rx_q.size() == 0);
    chk(rx_aempty_o == (rx_q.size() <= GAP), "R7", "rx_aempty", rx_aempty_o, rx_q.size() <= GAP);
    chk(rx_word_o == rh, "R3", "rx_word", rx_word_o, rh);
  endtask

  // drive one cycle at the negedge, update the model, check at the next negedge
  task automatic step(input bit tpn, input logic [8:0] tw, input bit tp,
                      input bit rp, input logic [1:0] rk, input logic [7:0] rd, input bit rpn);
    bit tpush, tpop, rpush, rpop;
    logic [8:0] enc;
    tx_push_ni = tpn; tx_word_i = tw; tx_link_pop_i = tp;
    rx_link_push_i = rp; rx_link_kind_i = rk; rx_link_data_i = rd; rx_pop_ni = rpn;
    tpush = !tpn && tx_q.size() < DEPTH;
    tpop  = tp && tx_q.size() > 0;
    rpush = rp && rx_q.size() < DEPTH;
    rpop  = !rpn && rx_q.size() > 0;
    enc = (rk == 2'b00) ? {1'b0, rd} : (rk == 2'b01) ? 9'h100 : 9'h101;
    if (tpop) void'(tx_q.pop_front());
    if (tpush) tx_q.push_back(tw);
    if (rpop) void'(rx_q.pop_front());
    if (rpush) rx_q.push_back(enc);
    @(negedge clk_i);
    compare_all();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1, 9'h0, 0, 0, 2'b00, 8'h0, 1);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_ni = 1'b0;
    tx_push_ni = 1; tx_word_i = 0; tx_link_pop_i = 0;
    rx_link_push_i = 0; rx_link_kind_i = 0; rx_link_data_i = 0; rx_pop_ni = 1;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(!tx_full_o && !tx_afull_o && !tx_link_valid_o && !rx_link_full_o, "R1", "tx flags", tx_full_o, 0);
    chk(rx_empty_o && rx_aempty_o && rx_word_o == 0, "R1", "rx flags", rx_empty_o, 1);
    rst_ni = 1'b1;
    @(negedge clk_i);
    compare_all();

    // mixed random traffic, R2 R3 R9 R10
    for (int i = 0; i < 400; i++)
      step($urandom_range(0, 2) == 0, 9'($urandom), $urandom_range(0, 2) == 0,
           $urandom_range(0, 1) == 1, 2'($urandom), 8'($urandom), $urandom_range(0, 2) != 0);
    for (int i = 0; i < 300; i++) step(1, 9'h0, 1, 0, 2'b00, 8'h0, 0);

    // R4 R6 fill transmit past capacity
    for (int i = 0; i < DEPTH + 4; i++) step(0, 9'(i * 7), 0, 0, 2'b00, 8'h0, 1);
    chk(tx_full_o == 1, "R4", "full after overfill", tx_full_o, 1);
    chk(tx_link_data_o == 8'h00, "R4", "head kept", tx_link_data_o, 0);
    // R5 drain past empty
    for (int i = 0; i < DEPTH + 4; i++) step(1, 9'h0, 1, 0, 2'b00, 8'h0, 1);
    chk(tx_link_valid_o == 0, "R5", "tx empty", tx_link_valid_o, 0);

    // R8 at 120 words (afull) and at 119 words (not afull)
    for (int i = 0; i < DEPTH - GAP; i++) step(0, 9'(i), 0, 0, 2'b00, 8'h0, 1);
    for (int i = 0; i < 6; i++) step(0, 9'h1AA, 1, 0, 2'b00, 8'h0, 1);
    chk(tx_afull_o == 1 && tx_full_o == 0, "R8", "afull held at 120", tx_afull_o, 1);
    step(1, 9'h0, 1, 0, 2'b00, 8'h0, 1);
    for (int i = 0; i < 6; i++) step(0, 9'h101, 1, 0, 2'b00, 8'h0, 1);
    chk(tx_afull_o == 0, "R8", "afull clear at 119", tx_afull_o, 0);
    for (int i = 0; i < DEPTH; i++) step(1, 9'h0, 1, 0, 2'b00, 8'h0, 1);

    // R10 terminator words on the transmit side
    step(0, 9'h100, 0, 0, 2'b00, 8'h0, 1);
    chk(tx_link_eop_o == 1 && tx_link_eep_o == 0, "R10", "eop head", tx_link_eop_o, 1);
    step(0, 9'h101, 1, 0, 2'b00, 8'h0, 1);
    chk(tx_link_eep_o == 1 && tx_link_eop_o == 0, "R10", "eep head", tx_link_eep_o, 1);
    step(1, 9'h0, 1, 0, 2'b00, 8'h0, 1);

    // R9 and R3 receive encoding with fall-through and hold
    step(1, 9'h0, 0, 1, 2'b01, 8'h55, 1);
    chk(rx_word_o == 9'h100, "R9", "eop encode", rx_word_o, 9'h100);
    step(1, 9'h0, 0, 1, 2'b10, 8'h55, 1);
    step(1, 9'h0, 0, 1, 2'b11, 8'h55, 1);
    step(1, 9'h0, 0, 1, 2'b00, 8'hC3, 1);
    idle(4);
    chk(rx_word_o == 9'h100, "R3", "head held", rx_word_o, 9'h100);
    step(1, 9'h0, 0, 0, 2'b00, 8'h0, 0);
    chk(rx_word_o == 9'h101, "R9", "eep encode", rx_word_o, 9'h101);
    step(1, 9'h0, 0, 0, 2'b00, 8'h0, 0);
    chk(rx_word_o == 9'h101, "R9", "alt eep encode", rx_word_o, 9'h101);
    step(1, 9'h0, 0, 0, 2'b00, 8'h0, 0);
    chk(rx_word_o == 9'h0C3, "R9", "data encode", rx_word_o, 9'h0C3);
    step(1, 9'h0, 0, 0, 2'b00, 8'h0, 0);

    // R4 R7 R5 receive to full then past empty
    for (int i = 0; i < DEPTH + 3; i++) step(1, 9'h0, 0, 1, 2'b00, 8'(i), 1);
    chk(rx_link_full_o == 1, "R4", "rx full", rx_link_full_o, 1);
    for (int i = 0; i < DEPTH + 3; i++) step(1, 9'h0, 0, 0, 2'b00, 8'h0, 0);
    chk(rx_empty_o == 1, "R5", "rx empty after overpop", rx_empty_o, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule